// File: doc/BRIEF.md
# Variable-Page Address Translation Lookup

This block turns a 32-bit virtual address into a physical address in a single registered step. Two fixed address windows skip translation. With translation turned off, the remaining space maps straight through to 29 bits. Everything else is looked up in a small, fully associative table.

Each table slot holds the following:
- a virtual page number and a physical page number, both kept as address bits 31:10;
- an 8-bit address-space tag;
- valid, shared and dirty flags;
- a 2-bit page-size code;
- a 2-bit access-rights field.

The lookup reports one of three results: a hit with its physical address, a fault code, or a detected multiple hit. Slots are written one at a time through a load port. A replacement index counter advances on every table search so that a refill agent outside the block knows which slot to overwrite.

A requester drives an address, a write flag and a privilege flag for one cycle. One clock edge later the block presents a done pulse together with either the physical address or a fault code. The current address-space tag, a single-virtual-space flag, a translation enable and the counter's wrap boundary are static control inputs.

Top module: `vtlb_xlate`

## Requirements
- R1: After reset, `done` and `fault` are 0, `fault_code` is 0, `repl_idx` is 0, and every table slot is invalid.
- R2: A request with `req_valid` high gives `done` high on the next clock edge only. At that edge, `fault_code` is 0 and `fault` low on success, or `fault_code` holds the fault and `phys_addr` is 0.
- R3: Privileged addresses 0x80000000 to 0xBFFFFFFF map to the address with bits 31:29 cleared. Privileged addresses at or above 0xE0000000 map to themselves. Neither case faults.
- R4: A user access to either fixed window faults with code 0x0E0 for a read and 0x100 for a write. The exception is the window 0xE0000000 to 0xE4000000 inclusive, which maps to itself.
- R5: With `xlat_en` low, any address outside the fixed windows maps to the address with bits 31:29 cleared, with no fault.
- R6: Size code 0, 1, 2 and 3 selects a 1 KB, 4 KB, 64 KB or 1 MB page. Virtual page bits below the page size are ignored in the compare. The physical address is the page-masked physical page number (shifted by 10) OR the page-offset bits of the virtual address.
- R7: An invalid slot never matches. The tag compare is enforced when `single_virt` is 0 or the access is a user access. When enforced, a slot without the shared flag matches only if its tag equals `cur_asid`.
- R8: A search with no matching slot faults with code 0x040 for a read and 0x060 for a write.
- R9: A search that matches more than one slot faults with code 0x140. This fault takes priority over access-rights and dirty faults.
- R10: Rights bit 1 set allows user access, and rights bit 0 set allows writes. A single hit that breaks either rule faults with code 0x0A0 for a read and 0x0C0 for a write.
- R11: A permitted write that hits a slot with the dirty flag clear faults with code 0x080.
- R12: Each table search (translation enabled, outside the fixed windows) moves `repl_idx` to its value plus one. The result is replaced by 0 when it equals `wrap_bound` or ENTRIES-1. Any other cycle leaves `repl_idx` unchanged.
- R13: A load with `ld_en` high writes all fields of slot `ld_idx` at the clock edge. Lookups from the next cycle see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| req_priv | input | 1 | 1 = privileged access |
| cur_asid | input | ASIDW | Current address-space tag |
| single_virt | input | 1 | Single virtual space; privileged accesses skip the tag compare |
| xlat_en | input | 1 | Translation enable |
| wrap_bound | input | IW | Replacement counter wrap boundary |
| ld_en | input | 1 | Slot write strobe |
| ld_idx | input | IW | Slot to write |
| ld_vpn | input | 22 | Virtual page number (address bits 31:10) |
| ld_ppn | input | 22 | Physical page number (address bits 31:10) |
| ld_asid | input | ASIDW | Slot address-space tag |
| ld_valid | input | 1 | Slot valid flag |
| ld_shared | input | 1 | Slot shared flag |
| ld_dirty | input | 1 | Slot dirty flag |
| ld_size | input | 2 | Page-size code |
| ld_prot | input | 2 | Access rights |
| done | output | 1 | Result valid |
| fault | output | 1 | Result is a fault |
| fault_code | output | 12 | Fault code, 0 on success |
| phys_addr | output | 32 | Physical address, 0 on fault |
| repl_idx | output | IW | Replacement slot index |

## Verification
The multiple-hit fault is the hardest case to reach. Correct refill software never creates it, so the stimulus loads a 1 MB slot and a 4 KB slot whose ranges overlap. It then sends a user write that would also violate the rights field, which shows that the multiple-hit code wins. Driving the replacement counter to its last index takes a long run of table searches with the boundary parked at 0. The bench also repeats this with a small boundary, so that both wrap conditions and the no-move case for bypassed accesses are observed.

// File: rtl/vtlb_xlate.sv
module vtlb_xlate #(
  parameter int ENTRIES = 64,
  parameter int ASIDW   = 8,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [31:0]      req_addr,
  input  logic             req_write,
  input  logic             req_priv,
  input  logic [ASIDW-1:0] cur_asid,
  input  logic             single_virt,
  input  logic             xlat_en,
  input  logic [IW-1:0]    wrap_bound,
  input  logic             ld_en,
  input  logic [IW-1:0]    ld_idx,
  input  logic [21:0]      ld_vpn,
  input  logic [21:0]      ld_ppn,
  input  logic [ASIDW-1:0] ld_asid,
  input  logic             ld_valid,
  input  logic             ld_shared,
  input  logic             ld_dirty,
  input  logic [1:0]       ld_size,
  input  logic [1:0]       ld_prot,
  output logic             done,
  output logic             fault,
  output logic [11:0]      fault_code,
  output logic [31:0]      phys_addr,
  output logic [IW-1:0]    repl_idx
);
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);
  localparam logic [11:0] C_MISS_RD = 12'h040;
  localparam logic [11:0] C_MISS_WR = 12'h060;
  localparam logic [11:0] C_INIT_WR = 12'h080;
  localparam logic [11:0] C_VIOL_RD = 12'h0A0;
  localparam logic [11:0] C_VIOL_WR = 12'h0C0;
  localparam logic [11:0] C_AERR_RD = 12'h0E0;
  localparam logic [11:0] C_AERR_WR = 12'h100;
  localparam logic [11:0] C_MULTI   = 12'h140;

  function automatic logic [21:0] page_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    page_mask = 22'h3FFFFF;
      2'd1:    page_mask = 22'h3FFFFC;
      2'd2:    page_mask = 22'h3FFFC0;
      default: page_mask = 22'h3FFC00;
    endcase
  endfunction

  logic [21:0]      e_vpn  [ENTRIES];
  logic [21:0]      e_ppn  [ENTRIES];
  logic [ASIDW-1:0] e_asid [ENTRIES];
  logic [1:0]       e_sz   [ENTRIES];
  logic [1:0]       e_pr   [ENTRIES];
  logic [ENTRIES-1:0] e_v, e_sh, e_d;

  always_ff @(posedge clk) begin
    if (ld_en) begin
      e_vpn[ld_idx]  <= ld_vpn;
      e_ppn[ld_idx]  <= ld_ppn;
      e_asid[ld_idx] <= ld_asid;
      e_sz[ld_idx]   <= ld_size;
      e_pr[ld_idx]   <= ld_prot;
      e_sh[ld_idx]   <= ld_shared;
      e_d[ld_idx]    <= ld_dirty;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     e_v <= '0;
    else if (ld_en) e_v[ld_idx] <= ld_valid;
  end

  wire use_asid = !single_virt || !req_priv;

  logic [ENTRIES-1:0] hit;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit[g] = e_v[g]
                 && (e_sh[g] || !use_asid || e_asid[g] == cur_asid)
                 && ((req_addr[31:10] & page_mask(e_sz[g])) == (e_vpn[g] & page_mask(e_sz[g])));
  end

  logic [IW-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit[i]) sel = IW'(i);
  end

  wire        multi   = |(hit & (hit - 1'b1));
  wire [1:0]  sel_pr  = e_pr[sel];
  wire        sel_d   = e_d[sel];
  wire [31:0] off_msk = ~{page_mask(e_sz[sel]), 10'b0};
  wire [31:0] tlb_pa  = ({e_ppn[sel], 10'b0} & ~off_msk) | (req_addr & off_msk);

  wire in_p12   = req_addr[31:30] == 2'b10;
  wire in_p4    = &req_addr[31:29];
  wire bypass   = in_p12 || in_p4;
  wire sq_win   = in_p4 && req_addr <= 32'hE4000000;
  wire addr_err = bypass && !req_priv && !sq_win;
  wire search   = req_valid && !bypass && xlat_en;

  logic [11:0] code_n;
  logic [31:0] pa_n;
  always_comb begin
    code_n = '0;
    pa_n   = '0;
    if (bypass) begin
      if (addr_err) code_n = req_write ? C_AERR_WR : C_AERR_RD;
      else          pa_n   = in_p12 ? {3'b000, req_addr[28:0]} : req_addr;
    end else if (!xlat_en) begin
      pa_n = {3'b000, req_addr[28:0]};
    end else if (hit == '0) begin
      code_n = req_write ? C_MISS_WR : C_MISS_RD;
    end else if (multi) begin
      code_n = C_MULTI;
    end else if ((!req_priv && !sel_pr[1]) || (req_write && !sel_pr[0])) begin
      code_n = req_write ? C_VIOL_WR : C_VIOL_RD;
    end else if (req_write && !sel_d) begin
      code_n = C_INIT_WR;
    end else begin
      pa_n = tlb_pa;
    end
  end

  wire [IW-1:0] repl_inc = IW'(repl_idx + 1'b1);
  wire [IW-1:0] repl_nx  = (repl_inc == wrap_bound || repl_inc == LAST) ? '0 : repl_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_code <= '0;
      phys_addr  <= '0;
      repl_idx   <= '0;
    end else begin
      done <= req_valid;
      if (req_valid) begin
        fault_code <= code_n;
        phys_addr  <= pa_n;
        fault      <= code_n != '0;
      end
      if (search) repl_idx <= repl_nx;
    end
  end

  // R2
  done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done);
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !done);
  // R3
  low_window_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_priv && req_addr[31:30] == 2'b10 |=>
      !fault && phys_addr == {3'b000, $past(req_addr[28:0])});
  // R9
  multi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    search && multi |=> fault_code == C_MULTI);
  // R12
  repl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    repl_idx != LAST);
  // R12
  repl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !search |=> $stable(repl_idx));
  // R2
  fault_code_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> (fault_code == C_MISS_RD || fault_code == C_MISS_WR ||
      fault_code == C_INIT_WR || fault_code == C_VIOL_RD || fault_code == C_VIOL_WR ||
      fault_code == C_AERR_RD || fault_code == C_AERR_WR || fault_code == C_MULTI));
endmodule

// File: tb/vtlb_xlate_bench.sv
module vtlb_xlate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 64;
  localparam int IW = 6;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_priv = 0;
  logic [31:0] req_addr = 0;
  logic [7:0] cur_asid = 0;
  logic single_virt = 0, xlat_en = 0;
  logic [IW-1:0] wrap_bound = 0;
  logic ld_en = 0;
  logic [IW-1:0] ld_idx = 0;
  logic [21:0] ld_vpn = 0, ld_ppn = 0;
  logic [7:0] ld_asid = 0;
  logic ld_valid = 0, ld_shared = 0, ld_dirty = 0;
  logic [1:0] ld_size = 0, ld_prot = 0;
  logic done, fault;
  logic [11:0] fault_code;
  logic [31:0] phys_addr;
  logic [IW-1:0] repl_idx;

  vtlb_xlate u_vtlb_xlate (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0, mismatched = 0;
  logic [21:0] m_vpn [N];
  logic [21:0] m_ppn [N];
  logic [7:0]  m_asid [N];
  logic [1:0]  m_sz [N];
  logic [1:0]  m_pr [N];
  logic        m_v [N];
  logic        m_sh [N];
  logic        m_d [N];
  logic [IW-1:0] m_cnt = 0;

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pbits(input logic [1:0] sz);
    case (sz) 2'd0: return 10; 2'd1: return 12; 2'd2: return 16; default: return 20; endcase
  endfunction

  function automatic void model(input logic [31:0] a, input logic w, input logic p,
                                output logic [11:0] code, output logic [31:0] ph, output logic srch);
    int nh, hi, b;
    logic ua;
    logic [31:0] om;
    code = 0; ph = 0; srch = 0; nh = 0; hi = 0;
    if (a[31:30] == 2'b10 || a >= 32'hE0000000) begin
      if (!p && !(a >= 32'hE0000000 && a <= 32'hE4000000)) code = w ? 12'h100 : 12'h0E0;
      else ph = (a[31:30] == 2'b10) ? (a & 32'h1FFFFFFF) : a;
    end else if (!xlat_en) begin
      ph = a & 32'h1FFFFFFF;
    end else begin
      srch = 1;
      ua = !single_virt || !p;
      for (int i = 0; i < N; i++) begin
        b = pbits(m_sz[i]);
        if (m_v[i] && (m_sh[i] || !ua || m_asid[i] == cur_asid) &&
            ((a >> b) == ({m_vpn[i], 10'b0} >> b))) begin
          nh++; hi = i;
        end
      end
      if (nh == 0) code = w ? 12'h060 : 12'h040;
      else if (nh > 1) code = 12'h140;
      else if ((!p && !m_pr[hi][1]) || (w && !m_pr[hi][0])) code = w ? 12'h0C0 : 12'h0A0;
      else if (w && !m_d[hi]) code = 12'h080;
      else begin
        om = (32'd1 << pbits(m_sz[hi])) - 1;
        ph = ({m_ppn[hi], 10'b0} & ~om) | (a & om);
      end
    end
  endfunction

  task automatic load(input int idx, input logic [31:0] va, input logic [21:0] ppn, input logic [7:0] asid,
                      input logic v, input logic sh, input logic d, input logic [1:0] sz, input logic [1:0] pr);
    @(negedge clk);
    ld_en = 1; ld_idx = IW'(idx); ld_vpn = va[31:10]; ld_ppn = ppn; ld_asid = asid;
    ld_valid = v; ld_shared = sh; ld_dirty = d; ld_size = sz; ld_prot = pr;
    @(negedge clk);
    ld_en = 0;
    m_vpn[idx] = va[31:10]; m_ppn[idx] = ppn; m_asid[idx] = asid; m_v[idx] = v;
    m_sh[idx] = sh; m_d[idx] = d; m_sz[idx] = sz; m_pr[idx] = pr;
  endtask

  task automatic look(input logic [31:0] a, input logic w, input logic p, input string tag);
    logic [11:0] ec; logic [31:0] ep; logic s; logic [IW-1:0] inc;
    model(a, w, p, ec, ep, s);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w; req_priv = p;
    @(negedge clk);
    req_valid = 0;
    if (s) begin
      inc = IW'(m_cnt + 1);
      m_cnt = (inc == wrap_bound || inc == IW'(N - 1)) ? '0 : inc;
    end
    cmp("R2 done", {31'b0, done}, 1);
    cmp(tag, {20'b0, fault_code}, {20'b0, ec});
    cmp(tag, phys_addr, ep);
    cmp("R2 fault", {31'b0, fault}, {31'b0, ec != 0});
    cmp("R12 repl_idx", {26'b0, repl_idx}, {26'b0, m_cnt});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog R2 actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] byp [10];
    logic [31:0] off [5];
    logic [31:0] base [4];
    logic [31:0] tr [5];
    logic [31:0] av [3];
    logic [7:0]  asv [3];
    logic [31:0] sz_b;
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_sh[i] = 0; m_d[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0;
      m_asid[i] = 0; m_sz[i] = 0; m_pr[i] = 0;
    end
    #(CLK_PERIOD * 2 + 1);
    // R1 reset state
    cmp("R1 done", {31'b0, done}, 0);
    cmp("R1 fault", {31'b0, fault}, 0);
    cmp("R1 code", {20'b0, fault_code}, 0);
    cmp("R1 repl", {26'b0, repl_idx}, 0);
    @(negedge clk); rst_n = 1;
    xlat_en = 1;
    look(32'h0001_0000, 0, 1, "R1 empty table miss");

    // R3 R4 fixed windows
    byp = '{32'h80000000, 32'h9FFFFFFC, 32'hBFFFFFFF, 32'hE0000000, 32'hE2345678,
            32'hE4000000, 32'hE4000001, 32'hFFFFFFFF, 32'hC0000000, 32'hDFFFFFFF};
    for (int i = 0; i < 10; i++)
      for (int p = 0; p < 2; p++)
        for (int w = 0; w < 2; w++)
          look(byp[i], w[0], p[0], p ? "R3" : "R4");

    // R5 translation off
    xlat_en = 0;
    tr = '{32'h0, 32'h12345678, 32'h7FFFFFFF, 32'hC0001234, 32'hDFFFFFFF};
    for (int i = 0; i < 5; i++)
      for (int p = 0; p < 2; p++)
        for (int w = 0; w < 2; w++)
          look(tr[i], w[0], p[0], "R5");
    xlat_en = 1;

    // R6 page sizes, junk low page bits in stored numbers
    cur_asid = 8'h11; single_virt = 0;
    base = '{32'h0040_0400, 32'h0050_3000, 32'h0062_0000, 32'h0100_0000};
    for (int s = 0; s < 4; s++)
      load(s, base[s] | (32'h0000_0400 * s * (s > 0 ? 1 : 0) & ((32'd1 << pbits(2'(s))) - 1)),
           22'h30000 + 22'(s * 22'h400) + 22'(s == 3 ? 22'h155 : 22'h0),
           8'h11, 1, 0, 1, 2'(s), 2'b11);
    for (int s = 0; s < 4; s++) begin
      sz_b = 32'd1 << pbits(2'(s));
      off = '{32'h0, sz_b - 1, sz_b, sz_b / 2 + 3, 32'hFFFFFFFF};
      for (int k = 0; k < 5; k++)
        for (int w = 0; w < 2; w++)
          look(base[s] + off[k], w[0], 1, "R6");
    end

    // R7 tag matching, shared and invalid slots
    load(10, 32'h0200_0000, 22'h1000, 8'h22, 1, 0, 1, 2'd1, 2'b11);
    load(11, 32'h0300_0000, 22'h1100, 8'h33, 1, 1, 1, 2'd1, 2'b11);
    load(12, 32'h0400_0000, 22'h1200, 8'h11, 0, 1, 1, 2'd1, 2'b11);
    av = '{32'h0200_0010, 32'h0300_0010, 32'h0400_0010};
    asv = '{8'h11, 8'h22, 8'h33};
    for (int t = 0; t < 3; t++)
      for (int sv = 0; sv < 2; sv++)
        for (int p = 0; p < 2; p++)
          for (int k = 0; k < 3; k++) begin
            cur_asid = asv[t]; single_virt = sv[0];
            look(av[k], 0, p[0], "R7");
          end
    cur_asid = 8'h11; single_virt = 0;

    // R9 overlapping slots beat rights fault
    load(20, 32'h0500_0000, 22'h2000, 8'h11, 1, 0, 0, 2'd3, 2'b00);
    load(21, 32'h0508_0000, 22'h2400, 8'h11, 1, 0, 0, 2'd1, 2'b00);
    look(32'h0508_0004, 1, 0, "R9 multi over rights");
    look(32'h0508_0FFC, 0, 1, "R9 multi read");
    look(32'h0500_0004, 1, 0, "R10 single hit user write");

    // R10 R11 rights and dirty sweep
    for (int k = 0; k < 8; k++)
      load(30 + k, 32'h0600_0000 + 32'(k) * 32'h1000, 22'h3000 + 22'(k * 4), 8'h11,
           1, 0, k[2], 2'd1, k[1:0]);
    for (int k = 0; k < 8; k++)
      for (int p = 0; p < 2; p++)
        for (int w = 0; w < 2; w++)
          look(32'h0600_0000 + 32'(k) * 32'h1000 + 32'h124, w[0], p[0], "R10,R11");

    // R8 misses
    look(32'h0700_0000, 0, 1, "R8 read miss");
    look(32'h0700_0000, 1, 0, "R8 write miss");

    // R12 counter wrap at a boundary then at the last index
    wrap_bound = 6'd5;
    for (int i = 0; i < 12; i++) look(32'h0700_1000, 0, 1, "R12 bound");
    look(32'h8000_0000, 0, 1, "R12 bypass no move");
    wrap_bound = 6'd0;
    for (int i = 0; i < 70; i++) look(32'h0700_2000, i[0], 1, "R12 last");

    // R13 overwrite then invalidate
    load(30, 32'h0600_0000, 22'h3ABCD, 8'h11, 1, 0, 1, 2'd1, 2'b11);
    look(32'h0600_0456, 1, 0, "R13 new contents");
    load(30, 32'h0600_0000, 22'h3ABCD, 8'h11, 0, 0, 1, 2'd1, 2'b11);
    look(32'h0600_0456, 0, 1, "R13 invalidated");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule